// File: doc/BRIEF.md
# Three-Tap FIR Step Execution Unit

This block is an execution unit for a DSP pipeline. It computes one complete output of a three-tap filter each time the decoder issues a filter-step opcode. In that same cycle it reads a fresh input sample from the input data memory at its own input pointer and multiplies the three most recent samples by three stored coefficients. It sums the products, clamps the sum to the 16-bit signed range, and writes the result to the output data memory at its own output pointer. Both pointers then advance. Because the sample history, the coefficients and both pointers are held inside the unit, the decoder only has to present an opcode.

Setup opcodes prepare the unit before a run. They clear the sample history, load both pointers from two register-file read ports, and load the coefficients, two at a time and then the third. The input memory read is combinational within the cycle, and the output memory write takes effect on the closing clock edge. A filter step can be issued on every cycle with no bubbles.

Top module: `fir3_step_unit`

## Requirements
- R1: After an active-low reset, both pointers, the sample history and the coefficients are zero, and `wr_en_o` is low.
- R2: A FIR step (op_i = 1) shifts the history: the sample read this cycle becomes the newest entry, the previous newest becomes the middle entry, and the oldest one is dropped.
- R3: During a FIR step, `wr_en_o` is high, `wr_addr_o` equals the output pointer, and `wr_data_o` equals new*c0 + newest_old*c1 + middle_old*c2. Here "new" is `rd_data_i` in that cycle, and all values are signed 16-bit integers.
- R4: A sum above 32767 is written as 32767.
- R5: A sum below -32768 is written as -32768.
- R6: `rd_addr_o` always shows the input pointer, and the pointer increments by one after each FIR step.
- R7: The output pointer increments by one after each FIR step.
- R8: Both pointers wrap from 16'hFFFF to 0.
- R9: CLRSAMP (op_i = 2) zeroes the sample history and leaves the pointers and coefficients unchanged.
- R10: SETPTR (op_i = 3) loads the input pointer from `reg_a_i` and the output pointer from `reg_b_i`.
- R11: SETC01 (op_i = 4) loads c0 from `reg_a_i` and c1 from `reg_b_i`. SETC2 (op_i = 5) loads c2 from `reg_a_i`.
- R12: NOP (op_i = 0) and the unused codes 6 and 7 change no state and do not raise `wr_en_o`.
- R13: FIR steps issued on consecutive cycles each produce a correct output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Opcode from the decoder |
| reg_a_i | input | 16 | First register-file operand |
| reg_b_i | input | 16 | Second register-file operand |
| rd_addr_o | output | 16 | Input memory address (input pointer) |
| rd_data_i | input | 16 | Input memory read data, same cycle |
| wr_en_o | output | 1 | Output memory write enable |
| wr_addr_o | output | 16 | Output memory address (output pointer) |
| wr_data_o | output | 16 | Saturated filter result |

## Verification
The situations that are hardest to reach are saturation at both rails and pointer wraparound. Saturation needs full-scale coefficients together with a history filled with full-scale samples. The stimulus loads extreme coefficients and points the input pointer at a run of full-scale memory words, then issues back-to-back steps until all three taps are loaded. Wraparound is reached by loading both pointers with 16'hFFFF and stepping twice.

// File: rtl/fir3_pkg.sv
`timescale 1ns/1ps
package fir3_pkg;
  localparam int NTAPS = 3;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_FIR     = 3'd1,
    OP_CLRSAMP = 3'd2,
    OP_SETPTR  = 3'd3,
    OP_SETC01  = 3'd4,
    OP_SETC2   = 3'd5
  } fir3_op_e;
endpackage

// File: rtl/fir3_delay_line.sv
`timescale 1ns/1ps
module fir3_delay_line #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          shift_i,
  input  logic                          clr_i,
  input  logic [DATA_W-1:0]             din_i,
  output logic [DEPTH-1:0][DATA_W-1:0]  tap_o
);

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    logic [DATA_W-1:0] nxt;
    if (k == 0) begin : g_head
      assign nxt = din_i;
    end else begin : g_body
      assign nxt = tap_o[k-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      tap_o[k] <= '0;
      else if (clr_i)   tap_o[k] <= '0;
      else if (shift_i) tap_o[k] <= nxt;
    end
  end

  AST_HEAD_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !clr_i) |=> tap_o[0] == $past(din_i)); // R2

  if (DEPTH > 1) begin : g_chain_chk
    AST_SHIFT_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (shift_i && !clr_i) |=> tap_o[1] == $past(tap_o[0])); // R2
  end

  AST_CLEAR_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> tap_o == '0); // R9

endmodule

// File: rtl/fir3_dot_sat.sv
`timescale 1ns/1ps
module fir3_dot_sat #(
  parameter int DATA_W = 16,
  parameter int NTAPS  = 3
) (
  input  logic [NTAPS-1:0][DATA_W-1:0] x_i,
  input  logic [NTAPS-1:0][DATA_W-1:0] c_i,
  output logic [DATA_W-1:0]            y_o
);
  localparam int PROD_W = 2 * DATA_W;
  localparam int SUM_W  = PROD_W + $clog2(NTAPS);
  localparam logic signed [SUM_W-1:0] MAX_V = SUM_W'((64'sd1 <<< (DATA_W-1)) - 1);
  localparam logic signed [SUM_W-1:0] MIN_V = -SUM_W'(64'sd1 <<< (DATA_W-1));

  logic signed [PROD_W-1:0] prod [NTAPS];
  logic signed [SUM_W-1:0]  sum;

  for (genvar k = 0; k < NTAPS; k++) begin : g_mul
    assign prod[k] = $signed(x_i[k]) * $signed(c_i[k]);
  end

  always_comb begin
    sum = '0;
    for (int k = 0; k < NTAPS; k++) sum = sum + SUM_W'(prod[k]);
  end

  always_comb begin
    if (sum > MAX_V)      y_o = MAX_V[DATA_W-1:0];
    else if (sum < MIN_V) y_o = MIN_V[DATA_W-1:0];
    else                  y_o = sum[DATA_W-1:0];
  end

  // clamp must never flip the sign of the true sum
  always_comb begin
    if (sum < 0) AST_SAT_SIGN_NEG: assert (y_o[DATA_W-1]); // R5
    if (sum > 0) AST_SAT_SIGN_POS: assert (!y_o[DATA_W-1]); // R4
  end

endmodule

// File: rtl/fir3_ptr.sv
`timescale 1ns/1ps
module fir3_ptr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (load_i) ptr_o <= load_val_i;
    else if (inc_i)  ptr_o <= ptr_o + ADDR_W'(1); // wraps naturally
  end
endmodule

// File: rtl/fir3_step_unit.sv
`timescale 1ns/1ps
module fir3_step_unit
  import fir3_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] reg_a_i,
  input  logic [DATA_W-1:0] reg_b_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int HIST = NTAPS - 1;

  fir3_op_e op;
  logic     is_fir, is_clr, is_setptr, is_setc01, is_setc2;

  logic [HIST-1:0][DATA_W-1:0]  hist;
  logic [NTAPS-1:0][DATA_W-1:0] x_vec;
  logic [NTAPS-1:0][DATA_W-1:0] coef;

  assign op        = fir3_op_e'(op_i);
  assign is_fir    = (op == OP_FIR);
  assign is_clr    = (op == OP_CLRSAMP);
  assign is_setptr = (op == OP_SETPTR);
  assign is_setc01 = (op == OP_SETC01);
  assign is_setc2  = (op == OP_SETC2);

  fir3_delay_line #(.DATA_W(DATA_W), .DEPTH(HIST)) u_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(is_fir),
    .clr_i  (is_clr),
    .din_i  (rd_data_i),
    .tap_o  (hist)
  );

  // tap 0 is the sample being read now; older taps come from history
  for (genvar k = 0; k < NTAPS; k++) begin : g_xvec
    if (k == 0) begin : g_new
      assign x_vec[k] = rd_data_i;
    end else begin : g_old
      assign x_vec[k] = hist[k-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coef <= '0;
    end else if (is_setc01) begin
      coef[0] <= reg_a_i;
      coef[1] <= reg_b_i;
    end else if (is_setc2) begin
      coef[2] <= reg_a_i;
    end
  end

  fir3_dot_sat #(.DATA_W(DATA_W), .NTAPS(NTAPS)) u_dot (
    .x_i(x_vec),
    .c_i(coef),
    .y_o(wr_data_o)
  );

  fir3_ptr #(.ADDR_W(ADDR_W)) u_in_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (is_setptr),
    .load_val_i(ADDR_W'(reg_a_i)),
    .inc_i     (is_fir),
    .ptr_o     (rd_addr_o)
  );

  fir3_ptr #(.ADDR_W(ADDR_W)) u_out_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (is_setptr),
    .load_val_i(ADDR_W'(reg_b_i)),
    .inc_i     (is_fir),
    .ptr_o     (wr_addr_o)
  );

  assign wr_en_o = is_fir;

  AST_IN_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd1) |=> rd_addr_o == ($past(rd_addr_o) + ADDR_W'(1))); // R6

  AST_OUT_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd1) |=> wr_addr_o == ($past(wr_addr_o) + ADDR_W'(1))); // R7

  AST_SETPTR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd3) |=> (rd_addr_o == ADDR_W'($past(reg_a_i))) &&
                       (wr_addr_o == ADDR_W'($past(reg_b_i)))); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd0 || op_i > 3'd5) |=> $stable(rd_addr_o) && $stable(wr_addr_o)); // R12

endmodule

// File: tb/fir3_step_unit_test.sv
`timescale 1ns/1ps
module fir3_step_unit_test;
  localparam time HALF = 4ns;  // 125 MHz

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic [15:0] reg_a_i = '0, reg_b_i = '0;
  logic [15:0] rd_addr_o, rd_data_i, wr_addr_o, wr_data_o;
  logic        wr_en_o;

  logic [15:0] mem [64];
  int checks = 0, fails = 0;

  // reference state
  int s0 = 0, s1 = 0, c0 = 0, c1 = 0, c2 = 0, ip = 0, opp = 0;

  always #HALF clk = ~clk;
  assign rd_data_i = mem[rd_addr_o[5:0]];

  fir3_step_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op_i), .reg_a_i(reg_a_i), .reg_b_i(reg_b_i),
    .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i), .wr_en_o(wr_en_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                      input string dtag, input string ptag);
    int nd;
    longint sum, y;
    @(negedge clk);
    op_i = op; reg_a_i = a; reg_b_i = b;
    #1;
    nd  = $signed(mem[ip % 64]);
    sum = longint'(nd) * c0 + longint'(s0) * c1 + longint'(s1) * c2;
    y   = (sum > 32767) ? 32767 : (sum < -32768) ? -32768 : sum;
    chk(rd_addr_o == 16'(ip), ptag, "rd_addr", rd_addr_o, ip);
    chk(wr_en_o == (op == 3'd1), (op == 3'd1) ? dtag : "R12", "wr_en", wr_en_o, op == 3'd1);
    if (op == 3'd1) begin
      chk(wr_addr_o == 16'(opp), (ptag == "R8") ? "R8" : "R7", "wr_addr", wr_addr_o, opp);
      chk($signed(wr_data_o) == y, dtag, "wr_data", $signed(wr_data_o), y);
    end
    @(posedge clk);
    case (op)
      3'd1: begin s1 = s0; s0 = nd; ip = (ip + 1) & 16'hFFFF; opp = (opp + 1) & 16'hFFFF; end
      3'd2: begin s0 = 0; s1 = 0; end
      3'd3: begin ip = a; opp = b; end
      3'd4: begin c0 = $signed(a); c1 = $signed(b); end
      3'd5: c2 = $signed(a);
      default: ;
    endcase
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(HALF * 2 * 150000);
    fails++;
    $display("FAIL R13 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'((i * 37) - 900);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk(rd_addr_o == 0, "R1", "rd_addr", rd_addr_o, 0);
    chk(wr_addr_o == 0, "R1", "wr_addr", wr_addr_o, 0);
    chk(wr_en_o == 0, "R1", "wr_en", wr_en_o, 0);
    // zero coefficients give zero output
    step(3'd1, 0, 0, "R1", "R6");
    step(3'd1, 0, 0, "R1", "R6");
    // setup
    step(3'd4, 16'd3, 16'hFFFE, "R11", "R6");
    step(3'd5, 16'd5, 0, "R11", "R6");
    step(3'd1, 0, 0, "R11", "R6");
    step(3'd3, 16'd4, 16'd100, "R10", "R10");
    step(3'd1, 0, 0, "R10", "R10");
    // back-to-back run
    for (int i = 0; i < 8; i++) step(3'd1, 0, 0, (i < 4) ? "R2" : "R13", "R6");
    step(3'd4, 16'd7, 16'd11, "R3", "R6");
    step(3'd5, 16'hFFF3, 0, "R3", "R6");
    for (int i = 0; i < 4; i++) step(3'd1, 0, 0, "R3", "R6");
    // clear keeps pointers and coefficients
    step(3'd2, 0, 0, "R9", "R9");
    step(3'd1, 0, 0, "R9", "R9");
    step(3'd1, 0, 0, "R9", "R9");
    // idle codes
    step(3'd0, 16'hAAAA, 16'h5555, "R12", "R12");
    step(3'd6, 16'h1234, 16'h4321, "R12", "R12");
    step(3'd7, 16'hFFFF, 16'hFFFF, "R12", "R12");
    step(3'd1, 0, 0, "R12", "R12");
    // positive saturation
    for (int i = 40; i < 44; i++) mem[i] = 16'h7FFF;
    step(3'd4, 16'h7FFF, 16'h7FFF, "R4", "R6");
    step(3'd5, 16'h7FFF, 0, "R4", "R6");
    step(3'd3, 16'd40, 16'd300, "R4", "R10");
    for (int i = 0; i < 3; i++) step(3'd1, 0, 0, "R4", "R6");
    // negative saturation
    step(3'd4, 16'h8000, 16'h8000, "R5", "R6");
    step(3'd5, 16'h8000, 0, "R5", "R6");
    step(3'd3, 16'd40, 16'd400, "R5", "R10");
    for (int i = 0; i < 3; i++) step(3'd1, 0, 0, "R5", "R6");
    // wraparound
    step(3'd3, 16'hFFFF, 16'hFFFF, "R8", "R8");
    step(3'd1, 0, 0, "R8", "R8");
    step(3'd1, 0, 0, "R8", "R8");
    step(3'd0, 0, 0, "R8", "R8");
    summary();
  end
endmodule